// File: doc/BRIEF.md
# Two-Way Page Translation Cache

This block holds recently used page translations for a processor with 4 KB pages. It keeps two independent caches: one answers instruction fetches, the other answers every data-side access. Each cache is two-way set associative. A set holds two entries and one recency bit. Each entry holds the full virtual page number as its tag and the second page-table word, which carries the physical page number and the attribute bits.

A lookup presents an effective address and an access kind, and gets an answer in the same cycle. The answer is a miss, a hit, or a changed-bit update, together with the physical address and a flag that marks a write-through or cache-inhibited view. Any change to the cache state takes effect at the next clock edge. A page-table walker outside the block supplies new entries through the fill port. Software-driven shootdowns use the invalidate port, which empties one set index in both caches.

Top module: `tlb2w`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. A miss, or a cycle with lk_valid low, drives lk_result=0, lk_paddr=0 and lk_wi=0.
- R2: The set index is address bits 17:12. The tag is the whole page number, bits 31:12. An entry with a different tag in the same set never hits. Page number 0xFFFFF can be cached like any other.
- R3: lk_result is 0 for a miss, 1 for a hit and 2 for a changed-bit update. On a hit, lk_paddr = {pte[31:12], vaddr[11:0]}. lk_wi is pte[6] (write-through) OR pte[5] (cache-inhibited).
- R4: Access kinds are coded 0 read, 1 write, 2 fetch, 3 data probe and 4 fetch probe; codes 5 to 7 act as a data probe. Kinds 2 and 4 use the instruction cache and all other kinds use the data cache, for lookups and fills alike.
- R5: A write (kind 1) that hits an entry whose changed bit pte[7] is 0 returns result 2 and sets that bit. The set's recency bit is not changed. The next write to the same page returns result 1.
- R6: A hit by kind 0, 1 or 2 that is not a changed-bit update sets the set's recency bit to the number of the way that hit.
- R7: A fill goes to way 1 when the recency bit is 0 and way 0 holds a valid tag; otherwise it goes to way 0. The recency bit then names the filled way.
- R8: Probe lookups (kinds 3 and 4) return hits and misses normally but leave the recency bit unchanged. Fills whose kind is a probe are dropped.
- R9: An invalidate empties both ways of the indexed set in both caches and clears that set's recency bit. All other sets are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_kind | input | 3 | Access kind of the lookup |
| lk_vaddr | input | 32 | Effective address to translate |
| lk_result | output | 2 | 0 miss, 1 hit, 2 changed-bit update |
| lk_paddr | output | 32 | Translated physical address |
| lk_wi | output | 1 | Write-through or cache-inhibited page |
| fill_valid | input | 1 | Install an entry from the walker |
| fill_kind | input | 3 | Access kind that caused the walk |
| fill_vaddr | input | 32 | Address whose page is installed |
| fill_pte | input | 32 | Second page-table word to store |
| inv_valid | input | 1 | Invalidate request |
| inv_vaddr | input | 32 | Address selecting the set to empty |

## Verification
The hardest behaviour to observe is that a probe hit leaves the recency bit alone, because that bit never reaches a port. The stimulus first sets up a set whose recency bit points at way 1. A data probe then hits way 0, and a fill follows in the same set. A later lookup shows which page was evicted: had the probe moved the recency bit, the wrong way would have been replaced. The same indirect method confirms victim choice after an invalidate. It also confirms that a changed-bit update does not disturb recency.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;

    localparam int unsigned VA_W      = 32;
    localparam int unsigned PG_SHIFT  = 12;
    localparam int unsigned VPN_W     = VA_W - PG_SHIFT;
    localparam int unsigned TAG_W     = VPN_W + 1;
    localparam int unsigned PTE_W     = 32;
    localparam int unsigned PTE_C_BIT = 7;
    localparam int unsigned PTE_W_BIT = 6;
    localparam int unsigned PTE_I_BIT = 5;

    // one spare tag bit: the empty marker can never equal a real page number
    localparam logic [TAG_W-1:0] TAG_NONE = '1;

    typedef enum logic [2:0] {
        ACC_READ   = 3'd0,
        ACC_WRITE  = 3'd1,
        ACC_FETCH  = 3'd2,
        ACC_RPROBE = 3'd3,
        ACC_FPROBE = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        RES_MISS    = 2'd0,
        RES_HIT     = 2'd1,
        RES_CHANGED = 2'd2
    } lk_res_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PTE_W-1:0] pte;
    } tlb_ent_t;

    typedef struct packed {
        tlb_ent_t ent1;
        tlb_ent_t ent0;
        logic     mru;
    } tlb_set_t;

    localparam tlb_set_t SET_EMPTY = '{
        ent1: '{tag: TAG_NONE, pte: '0},
        ent0: '{tag: TAG_NONE, pte: '0},
        mru:  1'b0
    };

    function automatic logic kind_is_fetch(input logic [2:0] k);
        return (k == ACC_FETCH) || (k == ACC_FPROBE);
    endfunction

    function automatic logic kind_is_probe(input logic [2:0] k);
        return !((k == ACC_READ) || (k == ACC_WRITE) || (k == ACC_FETCH));
    endfunction

endpackage

// File: rtl/tlb2w_match.sv
module tlb2w_match
    import tlb2w_pkg::*;
(
    input  tlb_ent_t         ent0_i,
    input  tlb_ent_t         ent1_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic             hit_o,
    output logic             way_o,
    output tlb_ent_t         ent_o
);

    logic [TAG_W-1:0] probe_tag;
    logic             h0;
    logic             h1;

    always_comb begin
        probe_tag = {1'b0, vpn_i};
        h0        = (ent0_i.tag == probe_tag);
        h1        = (ent1_i.tag == probe_tag);
        hit_o     = h0 || h1;
        way_o     = !h0 && h1;
        ent_o     = h0 ? ent0_i : ent1_i;
    end

endmodule

// File: rtl/tlb2w_victim.sv
module tlb2w_victim
    import tlb2w_pkg::*;
(
    input  logic             mru_i,
    input  logic [TAG_W-1:0] tag0_i,
    output logic             way_o
);

    always_comb begin
        way_o = !mru_i && (tag0_i != TAG_NONE);
    end

endmodule

// File: rtl/tlb2w_side.sv
module tlb2w_side
    import tlb2w_pkg::*;
#(
    parameter int unsigned SETS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_en,
    input  logic [VPN_W-1:0]        lk_vpn,
    input  logic                    lk_write,
    input  logic                    lk_probe,
    input  logic                    fl_en,
    input  logic                    fl_probe,
    input  logic [VPN_W-1:0]        fl_vpn,
    input  logic [PTE_W-1:0]        fl_pte,
    input  logic                    iv_en,
    input  logic [$clog2(SETS)-1:0] iv_idx,
    output logic                    lk_hit,
    output logic                    lk_changed,
    output logic [PTE_W-1:0]        lk_pte
);

    localparam int unsigned IDX_W = $clog2(SETS);

    typedef struct packed {
        tlb_set_t [SETS-1:0] set;
    } side_st_t;

    side_st_t         st_q;
    side_st_t         st_d;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] fl_idx;
    tlb_set_t         lk_set;
    tlb_set_t         fl_set;
    logic             hit_any;
    logic             hit_way;
    tlb_ent_t         hit_ent;
    logic             vic_way;
    logic             fl_take;
    tlb_ent_t         new_ent;

    assign lk_idx  = lk_vpn[IDX_W-1:0];
    assign fl_idx  = fl_vpn[IDX_W-1:0];
    assign lk_set  = st_q.set[lk_idx];
    assign fl_set  = st_q.set[fl_idx];
    assign fl_take = fl_en && !fl_probe;
    assign new_ent = '{tag: {1'b0, fl_vpn}, pte: fl_pte};

    tlb2w_match u_match (
        .ent0_i (lk_set.ent0),
        .ent1_i (lk_set.ent1),
        .vpn_i  (lk_vpn),
        .hit_o  (hit_any),
        .way_o  (hit_way),
        .ent_o  (hit_ent)
    );

    tlb2w_victim u_victim (
        .mru_i  (fl_set.mru),
        .tag0_i (fl_set.ent0.tag),
        .way_o  (vic_way)
    );

    assign lk_hit     = lk_en && hit_any;
    assign lk_changed = lk_hit && lk_write && !hit_ent.pte[PTE_C_BIT];
    assign lk_pte     = hit_ent.pte;

    // lookup update first, then fill, then invalidate: later steps override
    always_comb begin
        st_d = st_q;
        if (lk_hit) begin
            if (lk_changed) begin
                if (hit_way) st_d.set[lk_idx].ent1.pte[PTE_C_BIT] = 1'b1;
                else         st_d.set[lk_idx].ent0.pte[PTE_C_BIT] = 1'b1;
            end else if (!lk_probe) begin
                st_d.set[lk_idx].mru = hit_way;
            end
        end
        if (fl_take) begin
            if (vic_way) st_d.set[fl_idx].ent1 = new_ent;
            else         st_d.set[fl_idx].ent0 = new_ent;
            st_d.set[fl_idx].mru = vic_way;
        end
        if (iv_en) begin
            st_d.set[iv_idx] = SET_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                st_q.set[i] <= SET_EMPTY;
            end
        end else begin
            st_q <= st_d;
        end
    end

    AST_RECENT_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_probe && !lk_changed && !fl_take && !iv_en)
        |=> (st_q.set[$past(lk_idx)].mru == $past(hit_way))); // R6

    AST_CHANGED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_changed && !fl_take && !iv_en)
        |=> ($past(hit_way) ? st_q.set[$past(lk_idx)].ent1.pte[PTE_C_BIT]
                            : st_q.set[$past(lk_idx)].ent0.pte[PTE_C_BIT])); // R5

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_take && !iv_en)
        |=> ((st_q.set[$past(fl_idx)].ent0.tag == {1'b0, $past(fl_vpn)}) ||
             (st_q.set[$past(fl_idx)].ent1.tag == {1'b0, $past(fl_vpn)}))); // R7

    AST_PROBE_FILL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && fl_probe && !lk_en && !iv_en) |=> $stable(st_q)); // R8

    AST_INVALIDATE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        iv_en |=> ((st_q.set[$past(iv_idx)].ent0.tag == TAG_NONE) &&
                   (st_q.set[$past(iv_idx)].ent1.tag == TAG_NONE) &&
                   !st_q.set[$past(iv_idx)].mru)); // R9

endmodule

// File: rtl/tlb2w.sv
module tlb2w
    import tlb2w_pkg::*;
#(
    parameter int unsigned SETS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [2:0]  lk_kind,
    input  logic [31:0] lk_vaddr,
    output logic [1:0]  lk_result,
    output logic [31:0] lk_paddr,
    output logic        lk_wi,
    input  logic        fill_valid,
    input  logic [2:0]  fill_kind,
    input  logic [31:0] fill_vaddr,
    input  logic [31:0] fill_pte,
    input  logic        inv_valid,
    input  logic [31:0] inv_vaddr
);

    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned NSIDE = 2;

    logic             lk_side;
    logic             fl_side;
    logic [VPN_W-1:0] lk_vpn;
    logic [VPN_W-1:0] fl_vpn;
    logic [IDX_W-1:0] iv_idx;
    logic [NSIDE-1:0] side_hit;
    logic [NSIDE-1:0] side_chg;
    logic [PTE_W-1:0] side_pte [NSIDE];
    logic [PTE_W-1:0] sel_pte;
    lk_res_e          res;

    assign lk_side = kind_is_fetch(lk_kind);
    assign fl_side = kind_is_fetch(fill_kind);
    assign lk_vpn  = lk_vaddr[VA_W-1:PG_SHIFT];
    assign fl_vpn  = fill_vaddr[VA_W-1:PG_SHIFT];
    assign iv_idx  = inv_vaddr[PG_SHIFT+IDX_W-1:PG_SHIFT];

    // side 0 serves data accesses, side 1 serves instruction fetches
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        tlb2w_side #(.SETS(SETS)) u_side (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_en      (lk_valid && (lk_side == (g == 1))),
            .lk_vpn     (lk_vpn),
            .lk_write   (lk_kind == ACC_WRITE),
            .lk_probe   (kind_is_probe(lk_kind)),
            .fl_en      (fill_valid && (fl_side == (g == 1))),
            .fl_probe   (kind_is_probe(fill_kind)),
            .fl_vpn     (fl_vpn),
            .fl_pte     (fill_pte),
            .iv_en      (inv_valid),
            .iv_idx     (iv_idx),
            .lk_hit     (side_hit[g]),
            .lk_changed (side_chg[g]),
            .lk_pte     (side_pte[g])
        );
    end

    always_comb begin
        sel_pte  = side_pte[lk_side];
        res      = RES_MISS;
        lk_paddr = '0;
        lk_wi    = 1'b0;
        if (side_hit[lk_side]) begin
            res      = side_chg[lk_side] ? RES_CHANGED : RES_HIT;
            lk_paddr = {sel_pte[PTE_W-1:PTE_W-VPN_W], lk_vaddr[PG_SHIFT-1:0]};
            lk_wi    = sel_pte[PTE_W_BIT] || sel_pte[PTE_I_BIT];
        end
    end

    assign lk_result = res;

    logic unused_bits;
    assign unused_bits = ^{fill_vaddr[PG_SHIFT-1:0], inv_vaddr[VA_W-1:PG_SHIFT+IDX_W],
                           inv_vaddr[PG_SHIFT-1:0], side_pte[0][PTE_C_BIT+4:PTE_C_BIT],
                           side_pte[0][PTE_I_BIT-1:0], side_pte[1][PTE_C_BIT+4:PTE_C_BIT],
                           side_pte[1][PTE_I_BIT-1:0]};

    AST_IDLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> ((lk_result == RES_MISS) && (lk_paddr == '0) && !lk_wi)); // R1

    AST_HIT_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result != RES_MISS) |-> side_hit[lk_side]); // R4

endmodule

// File: tb/tlb2w_bench.sv
module tlb2w_bench;

    localparam logic [1:0] OP_LK = 2'd0;
    localparam logic [1:0] OP_FL = 2'd1;
    localparam logic [1:0] OP_IV = 2'd2;
    localparam logic [2:0] K_RD  = 3'd0;
    localparam logic [2:0] K_WR  = 3'd1;
    localparam logic [2:0] K_FE  = 3'd2;
    localparam logic [2:0] K_RP  = 3'd3;
    localparam logic [2:0] K_FP  = 3'd4;
    localparam logic [1:0] MISS  = 2'd0;
    localparam logic [1:0] HIT   = 2'd1;
    localparam logic [1:0] CHG   = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  kind;
        logic [31:0] addr;
        logic [31:0] pte;
        logic [1:0]  res;
        logic [31:0] pa;
        logic        wi;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 39;
    localparam vec_t VECS [NVEC] = '{
        '{OP_LK, K_RD, 32'h00012345, 32'h0,        MISS, 32'h0,        1'b0, 4'd1}, // R1
        '{OP_FL, K_RD, 32'h00012000, 32'hABCDE000, MISS, 32'h0,        1'b0, 4'd7},
        '{OP_LK, K_RD, 32'h00012345, 32'h0,        HIT,  32'hABCDE345, 1'b0, 4'd3}, // R3
        '{OP_LK, K_FE, 32'h00012345, 32'h0,        MISS, 32'h0,        1'b0, 4'd4}, // R4
        '{OP_LK, K_WR, 32'h00012678, 32'h0,        CHG,  32'hABCDE678, 1'b0, 4'd5}, // R5
        '{OP_LK, K_WR, 32'h00012678, 32'h0,        HIT,  32'hABCDE678, 1'b0, 4'd5},
        '{OP_FL, K_RD, 32'h00052000, 32'h11111060, MISS, 32'h0,        1'b0, 4'd7}, // R7
        '{OP_LK, K_RD, 32'h00052ABC, 32'h0,        HIT,  32'h11111ABC, 1'b1, 4'd3},
        '{OP_LK, K_RD, 32'h00012000, 32'h0,        HIT,  32'hABCDE000, 1'b0, 4'd6}, // R6
        '{OP_FL, K_RD, 32'h00092000, 32'h22222080, MISS, 32'h0,        1'b0, 4'd7},
        '{OP_LK, K_RD, 32'h00052000, 32'h0,        MISS, 32'h0,        1'b0, 4'd7},
        '{OP_LK, K_RD, 32'h00092004, 32'h0,        HIT,  32'h22222004, 1'b0, 4'd6},
        '{OP_LK, K_WR, 32'h00092008, 32'h0,        HIT,  32'h22222008, 1'b0, 4'd5},
        '{OP_LK, K_RP, 32'h00012010, 32'h0,        HIT,  32'hABCDE010, 1'b0, 4'd8}, // R8
        '{OP_FL, K_RD, 32'h000D2000, 32'h33333000, MISS, 32'h0,        1'b0, 4'd8},
        '{OP_LK, K_RD, 32'h00012000, 32'h0,        MISS, 32'h0,        1'b0, 4'd8},
        '{OP_LK, K_RD, 32'h000D2FFF, 32'h0,        HIT,  32'h33333FFF, 1'b0, 4'd8},
        '{OP_LK, K_RD, 32'h00092000, 32'h0,        HIT,  32'h22222000, 1'b0, 4'd8},
        '{OP_FL, K_RP, 32'h00400000, 32'h44444000, MISS, 32'h0,        1'b0, 4'd8},
        '{OP_LK, K_RD, 32'h00400000, 32'h0,        MISS, 32'h0,        1'b0, 4'd8},
        '{OP_FL, K_FE, 32'h00400000, 32'h55555020, MISS, 32'h0,        1'b0, 4'd4},
        '{OP_LK, K_FE, 32'h00400123, 32'h0,        HIT,  32'h55555123, 1'b1, 4'd4},
        '{OP_LK, K_RD, 32'h00400123, 32'h0,        MISS, 32'h0,        1'b0, 4'd4},
        '{OP_LK, K_FP, 32'h00400004, 32'h0,        HIT,  32'h55555004, 1'b1, 4'd8},
        '{OP_FL, K_FE, 32'h00012000, 32'h66666000, MISS, 32'h0,        1'b0, 4'd4},
        '{OP_LK, K_FE, 32'h00012ABC, 32'h0,        HIT,  32'h66666ABC, 1'b0, 4'd4},
        '{OP_IV, K_RD, 32'h7FF12000, 32'h0,        MISS, 32'h0,        1'b0, 4'd9}, // R9
        '{OP_LK, K_FE, 32'h00012ABC, 32'h0,        MISS, 32'h0,        1'b0, 4'd9},
        '{OP_LK, K_RD, 32'h00092000, 32'h0,        MISS, 32'h0,        1'b0, 4'd9},
        '{OP_LK, K_RD, 32'h000D2000, 32'h0,        MISS, 32'h0,        1'b0, 4'd9},
        '{OP_LK, K_FE, 32'h00400000, 32'h0,        HIT,  32'h55555000, 1'b1, 4'd9},
        '{OP_FL, K_RD, 32'h00012000, 32'h77777000, MISS, 32'h0,        1'b0, 4'd7},
        '{OP_FL, K_RD, 32'h00052000, 32'h88888000, MISS, 32'h0,        1'b0, 4'd7},
        '{OP_LK, K_RD, 32'h00012111, 32'h0,        HIT,  32'h77777111, 1'b0, 4'd7},
        '{OP_LK, K_RD, 32'h00052222, 32'h0,        HIT,  32'h88888222, 1'b0, 4'd7},
        '{OP_LK, K_RD, 32'hFFFFF800, 32'h0,        MISS, 32'h0,        1'b0, 4'd2}, // R2
        '{OP_FL, K_RD, 32'hFFFFF000, 32'h99999000, MISS, 32'h0,        1'b0, 4'd2},
        '{OP_LK, K_RD, 32'hFFFFF800, 32'h0,        HIT,  32'h99999800, 1'b0, 4'd2},
        '{OP_LK, K_RD, 32'h0003F800, 32'h0,        MISS, 32'h0,        1'b0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [2:0]  lk_kind = '0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_result;
    logic [31:0] lk_paddr;
    logic        lk_wi;
    logic        fill_valid = 1'b0;
    logic [2:0]  fill_kind = '0;
    logic [31:0] fill_vaddr = '0;
    logic [31:0] fill_pte = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_vaddr = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tlb2w u_tlb2w (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_kind    (lk_kind),
        .lk_vaddr   (lk_vaddr),
        .lk_result  (lk_result),
        .lk_paddr   (lk_paddr),
        .lk_wi      (lk_wi),
        .fill_valid (fill_valid),
        .fill_kind  (fill_kind),
        .fill_vaddr (fill_vaddr),
        .fill_pte   (fill_pte),
        .inv_valid  (inv_valid),
        .inv_vaddr  (inv_vaddr)
    );

    task automatic check(input int rq, input logic [1:0] er, input logic [31:0] ep, input logic ew);
        n_checks++;
        if (lk_result !== er || lk_paddr !== ep || lk_wi !== ew) begin
            n_fail++;
            $display("FAIL R%0d: got res=%0d pa=%h wi=%b, expected res=%0d pa=%h wi=%b",
                     rq, lk_result, lk_paddr, lk_wi, er, ep, ew);
        end
    endtask

    task automatic idle_inputs();
        lk_valid   = 1'b0;
        fill_valid = 1'b0;
        inv_valid  = 1'b0;
    endtask

    task automatic lookup(input logic [2:0] k, input logic [31:0] a);
        @(negedge clk);
        idle_inputs();
        lk_valid = 1'b1;
        lk_kind  = k;
        lk_vaddr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            @(negedge clk);
            idle_inputs();
            case (VECS[i].op)
                OP_LK: begin
                    lk_valid = 1'b1; lk_kind = VECS[i].kind; lk_vaddr = VECS[i].addr;
                end
                OP_FL: begin
                    fill_valid = 1'b1; fill_kind = VECS[i].kind;
                    fill_vaddr = VECS[i].addr; fill_pte = VECS[i].pte;
                end
                default: begin
                    inv_valid = 1'b1; inv_vaddr = VECS[i].addr;
                end
            endcase
            #1;
            if (VECS[i].op == OP_LK) check(int'(VECS[i].rq), VECS[i].res, VECS[i].pa, VECS[i].wi);
        end

        // R1: idle cycle on a cached page reports nothing
        @(negedge clk);
        idle_inputs();
        lk_kind = K_RD; lk_vaddr = 32'h00012111;
        #1;
        check(1, MISS, 32'h0, 1'b0);

        // R5: changed-bit update leaves recency alone; set 0x12 holds 77777 (way0) and 88888 (way1, mru=1)
        lookup(K_WR, 32'h00012004);
        check(5, CHG, 32'h77777004, 1'b0);
        @(negedge clk);
        idle_inputs();
        fill_valid = 1'b1; fill_kind = K_RD; fill_vaddr = 32'h00112000; fill_pte = 32'hAAAAA000;
        lookup(K_RD, 32'h00052000);
        check(5, HIT, 32'h88888000, 1'b0);
        lookup(K_RD, 32'h00012000);
        check(5, MISS, 32'h0, 1'b0);

        // R1: reset empties both caches
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(K_FE, 32'h00400000);
        check(1, MISS, 32'h0, 1'b0);
        lookup(K_RD, 32'hFFFFF000);
        check(1, MISS, 32'h0, 1'b0);

        @(negedge clk);
        idle_inputs();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule